// File: doc/BRIEF.md
# Serial Flash Fast-Read Master

This block is an SPI master that carries out one fast-read transaction against a serial flash. The host requests a read by pulsing a start strobe with a 24-bit start address and a length in bytes. The block lowers chip select and shifts out the read opcode 0x0B, the address (most significant byte first) and one dummy byte. It then gathers the bytes the flash returns and hands them to the host as 32-bit words over a valid/ready handshake.

SCK runs at half the system clock. At that rate half an SCK period is too short to meet the input setup time of the receiving flop. The block therefore uses one clock phase setting for the command, address and dummy bytes, and switches to the other setting for the data bytes. In the command part, MOSI changes on the trailing SCK edge and the flash samples it on the leading edge. In the data part, the bit the flash launches on a trailing edge is captured on the following trailing edge, one full SCK period later. The first data bit is launched on the trailing edge of the last dummy bit, so the switch costs no extra SCK cycle. If the host stops accepting words, SCK is held at its idle level between bytes and no data is lost.

Top module: `sfr_read_master`

## Requirements
- R1: During and directly after reset, o_cs_n is 1, o_sck is at the idle level CPOL, o_mosi is 0, o_busy is 0 and o_valid is 0.
- R2: A start is accepted when o_busy is 0 and the length is 4 or more. On the next clock o_cs_n is 0 and o_busy is 1, with o_sck still idle. One clock later o_sck makes its first leading edge, from idle to the active level (not CPOL).
- R3: The first 40 SCK cycles carry 0x0B, then the three address bytes, then 0x00, each byte MSB first. MOSI changes only together with a trailing SCK edge, so it is stable across every leading edge.
- R4: While a transaction runs, SCK is never active for more than one system clock (an SCK period is two clocks when not stalled). Whenever o_cs_n is 1, o_sck is at the idle level CPOL.
- R5: In the data phase, the MISO bit that the flash changes on the trailing edge of SCK cycle k is the bit captured for cycle k+1. Data bit 0 is the one launched on the trailing edge of SCK cycle 40, the last dummy bit.
- R6: Data words are packed MSB first. The first received byte of each group of four goes in bits 31:24 and the fourth goes in bits 7:0.
- R7: A transaction has exactly 40 + 8*B SCK cycles, where B is the length with its two low bits cleared. o_cs_n returns to 1, and o_busy to 0, on the clock after the last trailing edge.
- R8: While o_valid is 1 and i_ready is 0, o_valid stays 1 and o_data holds its value. A byte that would complete a word does not start while a word is still waiting; SCK rests idle with chip select low instead. Every word is delivered, in order.
- R9: A start pulse while o_busy is 1 is ignored. It affects neither the current transaction nor any later one.
- R10: The two low bits of the length are ignored. A start whose length is below 4 is ignored and leaves o_cs_n at 1 and o_busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | Start strobe for a read |
| i_addr | input | 24 | Flash start address |
| i_len | input | 16 | Length in bytes (low two bits ignored) |
| o_busy | output | 1 | High from an accepted start until chip select is released |
| o_data | output | 32 | Received word, first byte in bits 31:24 |
| o_valid | output | 1 | o_data holds a word for the host |
| i_ready | input | 1 | Host accepts o_data |
| o_cs_n | output | 1 | Flash chip select, active low |
| o_sck | output | 1 | Serial clock, idle level CPOL |
| o_mosi | output | 1 | Serial data to the flash |
| i_miso | input | 1 | Serial data from the flash |

## Verification
Two events can meet in the same clock. One is the host taking a pending word. The other is the block deciding whether to start the byte that completes the next word. When they meet, the word must be consumed and the byte started on that one edge, with no stall and no second copy. The bench provokes this by toggling ready in a short repeating pattern, and also by holding it low through a long window and then raising it. A flash model that launches bits on trailing edges judges the result: it checks the words in order, the exact SCK count and the chip-select release timing.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_DATA = 2'd2,
      ST_HOLD = 2'd3
   } sfr_state_e;

   localparam int unsigned SFR_BYTE_W = 8;
   localparam int unsigned SFR_WORD_W = 32;
endpackage

// File: rtl/sfr_cmd_shift.sv
module sfr_cmd_shift #(
   parameter int unsigned ADDR_BYTES  = 3,
   parameter int unsigned DUMMY_BYTES = 1,
   parameter logic [7:0]  OPCODE      = 8'h0B,
   localparam int unsigned ADDR_W     = 8 * ADDR_BYTES,
   localparam int unsigned DUMMY_W    = 8 * DUMMY_BYTES,
   localparam int unsigned CMD_BITS   = 8 + ADDR_W + DUMMY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [ADDR_W-1:0] addr,
   output logic              mosi
);
   logic [CMD_BITS-1:0] sh_q;

   // opcode, address and dummy leave MSB first; zeros follow once emptied
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= {OPCODE, addr, {DUMMY_W{1'b0}}};
      end else if (shift) begin
         sh_q <= {sh_q[CMD_BITS-2:0], 1'b0};
      end
   end

   assign mosi = sh_q[CMD_BITS-1];
endmodule

// File: rtl/sfr_rx_pack.sv
module sfr_rx_pack #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              word_done,
   input  logic              bit_in,
   input  logic              ready,
   output logic [WORD_W-1:0] data,
   output logic              valid
);
   logic [WORD_W-2:0] acc_q;
   logic [WORD_W-1:0] acc_nxt;

   assign acc_nxt = {acc_q, bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (cap) begin
         acc_q <= acc_nxt[WORD_W-2:0];
      end
   end

   // a completed word always finds the holding register free (see top)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
      end else if (word_done) begin
         data  <= acc_nxt;
         valid <= 1'b1;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/sfr_sck_out.sv
module sfr_sck_out #(
   parameter bit CPOL = 1'b0
) (
   input  logic act,
   output logic sck
);
   generate
      if (CPOL) begin : g_idle_high
         assign sck = ~act;
      end else begin : g_idle_low
         assign sck = act;
      end
   endgenerate
endmodule

// File: rtl/sfr_read_master.sv
module sfr_read_master
   import sfr_pkg::*;
#(
   parameter int unsigned ADDR_BYTES  = 3,
   parameter int unsigned DUMMY_BYTES = 1,
   parameter int unsigned LEN_W       = 16,
   parameter logic [7:0]  OPCODE      = 8'h0B,
   parameter bit          CPOL        = 1'b0,
   localparam int unsigned ADDR_W     = 8 * ADDR_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  i_start,
   input  logic [ADDR_W-1:0]     i_addr,
   input  logic [LEN_W-1:0]      i_len,
   output logic                  o_busy,
   output logic [SFR_WORD_W-1:0] o_data,
   output logic                  o_valid,
   input  logic                  i_ready,
   output logic                  o_cs_n,
   output logic                  o_sck,
   output logic                  o_mosi,
   input  logic                  i_miso
);
   localparam int unsigned CMD_BITS = 8 * (1 + ADDR_BYTES + DUMMY_BYTES);
   localparam int unsigned CMD_CW   = $clog2(CMD_BITS);
   localparam int unsigned DBIT_W   = LEN_W + 3;
   localparam int unsigned WBIT_W   = $clog2(SFR_WORD_W);

   generate
      if (ADDR_BYTES == 0 || ADDR_BYTES > 4) begin : g_chk_addr
         $error("ADDR_BYTES must be 1..4");
      end
      if (DUMMY_BYTES > 4) begin : g_chk_dummy
         $error("DUMMY_BYTES must be 0..4");
      end
      if (LEN_W < 3 || LEN_W > 28) begin : g_chk_len
         $error("LEN_W must be 3..28");
      end
   endgenerate

   sfr_state_e        state_q;
   logic              act_q;
   logic [CMD_CW-1:0] cmd_cnt_q;
   logic [DBIT_W-1:0] dbit_q;
   logic [DBIT_W-1:0] dlast_q;
   logic [LEN_W-1:0]  len_wb;
   logic              accept;
   logic              stall;
   logic              cap;
   logic              word_done;
   logic              shift;

   assign len_wb = i_len & ~LEN_W'(3);
   assign accept = i_start && (state_q == ST_IDLE) && (len_wb != '0);

   // the byte that closes a word waits while the previous word is still held
   assign stall = (state_q == ST_DATA) && !act_q && (dbit_q[2:0] == 3'd0)
                  && (dbit_q[WBIT_W-1:3] == '1) && o_valid && !i_ready;

   assign shift     = (state_q == ST_CMD) && act_q;
   assign cap       = (state_q == ST_DATA) && act_q;
   assign word_done = cap && (dbit_q[WBIT_W-1:0] == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         act_q     <= 1'b0;
         o_cs_n    <= 1'b1;
         cmd_cnt_q <= '0;
         dbit_q    <= '0;
         dlast_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q   <= ST_CMD;
                  o_cs_n    <= 1'b0;
                  cmd_cnt_q <= '0;
                  dbit_q    <= '0;
                  dlast_q   <= {len_wb, 3'b000} - DBIT_W'(1);
               end
            end
            ST_CMD: begin
               if (!act_q) begin
                  act_q <= 1'b1;
               end else begin
                  act_q <= 1'b0;
                  if (cmd_cnt_q == CMD_CW'(CMD_BITS - 1)) begin
                     state_q <= ST_DATA;
                  end else begin
                     cmd_cnt_q <= cmd_cnt_q + CMD_CW'(1);
                  end
               end
            end
            ST_DATA: begin
               if (!act_q) begin
                  if (!stall) begin
                     act_q <= 1'b1;
                  end
               end else begin
                  act_q <= 1'b0;
                  if (dbit_q == dlast_q) begin
                     state_q <= ST_HOLD;
                  end else begin
                     dbit_q <= dbit_q + DBIT_W'(1);
                  end
               end
            end
            default: begin
               o_cs_n  <= 1'b1;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign o_busy = (state_q != ST_IDLE);

   sfr_cmd_shift #(
      .ADDR_BYTES (ADDR_BYTES),
      .DUMMY_BYTES(DUMMY_BYTES),
      .OPCODE     (OPCODE)
   ) u_cmd (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .shift(shift),
      .addr (i_addr),
      .mosi (o_mosi)
   );

   sfr_rx_pack #(
      .WORD_W(SFR_WORD_W)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .word_done(word_done),
      .bit_in   (i_miso),
      .ready    (i_ready),
      .data     (o_data),
      .valid    (o_valid)
   );

   sfr_sck_out #(
      .CPOL(CPOL)
   ) u_sck (
      .act(act_q),
      .sck(o_sck)
   );
endmodule

// File: rtl/sfr_read_master_chk.sv
module sfr_read_master_chk #(
   parameter bit CPOL = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        o_cs_n,
   input logic        o_sck,
   input logic        o_mosi,
   input logic        o_busy,
   input logic        o_valid,
   input logic [31:0] o_data,
   input logic        i_ready
);
   // R4: SCK rests at its idle level whenever chip select is high
   a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      o_cs_n |-> (o_sck == CPOL));

   // R4: the active level never lasts longer than one clock
   a_r4_short_active: assert property (@(posedge clk) disable iff (!rst_n)
      (o_sck != CPOL) |=> (o_sck == CPOL));

   // R2: the first leading edge follows chip select by one clock
   a_r2_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(o_cs_n) |=> (o_sck != CPOL));

   // R3: MOSI is steady across every leading edge
   a_r3_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!o_cs_n && (o_sck == CPOL)) |=> $stable(o_mosi));

   // R7: chip select is low only inside the busy window
   a_r7_cs_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !o_cs_n |-> o_busy);

   // R8: a refused word stays put
   a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !i_ready) |=> (o_valid && $stable(o_data)));
endmodule

bind sfr_read_master sfr_read_master_chk #(
   .CPOL(CPOL)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .o_cs_n (o_cs_n),
   .o_sck  (o_sck),
   .o_mosi (o_mosi),
   .o_busy (o_busy),
   .o_valid(o_valid),
   .o_data (o_data),
   .i_ready(i_ready)
);

// File: tb/sfr_read_master_tb.sv
module sfr_read_master_tb;
   localparam bit CPOL = 1'b0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_start = 1'b0;
   logic [23:0] i_addr = '0;
   logic [15:0] i_len = '0;
   logic        o_busy;
   logic [31:0] o_data;
   logic        o_valid;
   logic        i_ready = 1'b0;
   logic        o_cs_n;
   logic        o_sck;
   logic        o_mosi;
   logic        i_miso = 1'b1;

   always #4 clk = ~clk;

   sfr_read_master #(.CPOL(CPOL)) u_dut (
      .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_addr(i_addr), .i_len(i_len),
      .o_busy(o_busy), .o_data(o_data), .o_valid(o_valid), .i_ready(i_ready),
      .o_cs_n(o_cs_n), .o_sck(o_sck), .o_mosi(o_mosi), .i_miso(i_miso)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] fbyte(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ {a[20:16], 3'b101};
   endfunction

   // reference model state
   logic [31:0] exp_q[$];
   int          exp_bytes = 0;
   int          rdy_mode = 0;
   int          cyc = 0;
   int          lead_cnt = 0;
   int          byte_ptr = 0;
   int          bit_ptr = 0;
   int          trail_age = 0;
   logic [39:0] cmd_seen = '0;
   logic [39:0] cmd_exp = '0;
   logic [23:0] fl_addr = '0;
   bit          prev_act = 1'b0;
   bit          prev_cs = 1'b1;
   bit          prev_valid = 1'b0;
   bit          prev_ready = 1'b0;
   logic [31:0] prev_data = '0;

   always @(negedge clk) begin
      bit          act;
      bit          r;
      logic [7:0]  b;
      logic [31:0] w;
      act = (o_sck != CPOL);
      cyc++;
      if (rst_n) begin
         if (prev_cs && !o_cs_n) begin
            lead_cnt = 0; byte_ptr = 0; bit_ptr = 0; cmd_seen = '0;
         end
         if (!o_cs_n) begin
            if (act && !prev_act) begin
               if (lead_cnt < 40) cmd_seen = {cmd_seen[38:0], o_mosi};
               lead_cnt++;
               if (lead_cnt == 32) fl_addr = cmd_seen[23:0];
            end
            if (!act && prev_act) begin
               trail_age = 0;
               // R5: flash launches a data bit on each trailing edge from cycle 40 on
               if (lead_cnt >= 40) begin
                  b = fbyte(fl_addr + 24'(byte_ptr));
                  i_miso = b[7 - bit_ptr];
                  bit_ptr++;
                  if (bit_ptr == 8) begin bit_ptr = 0; byte_ptr++; end
               end
            end else begin
               trail_age++;
            end
         end
         if (prev_act) check(!act, "R4", "sck active two clocks", act, 0);
         if (!prev_cs && o_cs_n) begin
            check(lead_cnt == 40 + 8 * exp_bytes, "R7", "sck cycles", lead_cnt, 40 + 8 * exp_bytes);
            check(trail_age == 0, "R7", "cs release delay", trail_age, 0);
            check(!o_busy, "R7", "busy at cs release", o_busy, 0);
            check(cmd_seen == cmd_exp, "R3", "command bits", cmd_seen, cmd_exp);
         end
         // host side
         case (rdy_mode)
            0: r = 1'b1;
            1: r = (cyc % 3 != 0);
            default: r = 1'b0;
         endcase
         if (o_valid && prev_valid && !prev_ready)
            check(o_data == prev_data, "R8", "held word changed", o_data, prev_data);
         if (o_valid && r) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected word", o_data, 0);
            end else begin
               w = exp_q.pop_front();
               check(o_data == w, "R6", "word value", o_data, w);
            end
         end
         i_ready = r;
         prev_valid = o_valid;
         prev_ready = r;
         prev_data = o_data;
      end
      prev_act = act;
      prev_cs = o_cs_n;
   end

   task automatic run_read(input logic [23:0] addr, input logic [15:0] len,
                           input int mode, input bit poke_busy, input bit long_stall);
      int nb;
      nb = int'(len) & ~3;
      exp_bytes = nb;
      cmd_exp = {8'h0B, addr, 8'h00};
      for (int k = 0; k < nb; k += 4) begin
         exp_q.push_back({fbyte(addr + 24'(k)), fbyte(addr + 24'(k + 1)),
                          fbyte(addr + 24'(k + 2)), fbyte(addr + 24'(k + 3))});
      end
      rdy_mode = long_stall ? 2 : mode;
      i_addr = addr; i_len = len; i_start = 1'b1;
      @(negedge clk);
      i_start = 1'b0;
      check(o_busy && !o_cs_n, "R2", "busy/cs after start", {o_busy, o_cs_n}, 2'b10);
      check(o_sck == CPOL, "R2", "sck idle in setup clock", o_sck, CPOL);
      @(negedge clk);
      check(o_sck != CPOL, "R2", "first leading edge", o_sck, !CPOL);
      if (poke_busy) begin
         repeat (20) @(negedge clk);
         i_addr = 24'hABCDEF; i_len = 16'd64; i_start = 1'b1;  // R9: ignored
         @(negedge clk);
         i_start = 1'b0;
      end
      if (long_stall) begin
         repeat (400) @(negedge clk);
         check(o_busy && !o_cs_n, "R8", "stalled transaction alive", {o_busy, o_cs_n}, 2'b10);
         check(o_sck == CPOL && o_valid, "R8", "sck idle while word held", {o_sck, o_valid}, {CPOL, 1'b1});
         rdy_mode = mode;
      end
      while (o_busy) @(negedge clk);
      repeat (6) @(negedge clk);
      check(exp_q.size() == 0, "R8", "words missing", exp_q.size(), 0);
      check(o_cs_n && !o_busy, "R9", "no extra transaction", {o_cs_n, o_busy}, 2'b10);
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(o_cs_n && !o_busy && !o_valid && !o_mosi && (o_sck == CPOL), "R1", "reset outputs",
            {o_cs_n, o_busy, o_valid, o_mosi, o_sck}, {1'b1, 1'b0, 1'b0, 1'b0, CPOL});
      rst_n = 1'b1;
      @(negedge clk);
      check(o_cs_n && !o_busy && (o_sck == CPOL), "R1", "after reset release",
            {o_cs_n, o_busy, o_sck}, {1'b1, 1'b0, CPOL});
      run_read(24'h123456, 16'd8, 0, 1'b1, 1'b0);   // R5 R6 R9
      run_read(24'hFFFFFE, 16'd16, 1, 1'b0, 1'b0);  // address wrap, ready pattern
      run_read(24'h000100, 16'd32, 0, 1'b0, 1'b1);  // R8 long stall
      run_read(24'h0A0B0C, 16'd6, 1, 1'b0, 1'b0);   // R10 low bits ignored
      // R10: length below four is ignored
      exp_bytes = 0;
      i_addr = 24'h555555; i_len = 16'd3; i_start = 1'b1;
      @(negedge clk);
      i_start = 1'b0;
      repeat (3) @(negedge clk);
      check(o_cs_n && !o_busy, "R10", "short start ignored", {o_cs_n, o_busy}, 2'b10);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule